// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the protocol side of a serial nonvolatile memory slave holding 8192 bytes. It watches the two bus lines, serial clock and serial data. Both lines are oversampled in the system clock domain. The block recognises START and STOP and checks the device address byte against a fixed prefix and three strap pins. It takes in a 13-bit word address and acknowledges every accepted byte. Write data leaves as one-cycle pulses carrying an address and a byte, meant for a page latch. A commit pulse follows the STOP that ends a write. Reads leave as one-cycle requests to the memory array. The array returns the byte on the next clock, and the block shifts it out most significant bit first.

An address counter survives from one transaction to the next. A write leaves it one past the last byte written, wrapping inside the 32-byte page. A read advances it through the whole space. This is how current-address reads and sequential reads work. A random read loads the counter with a write header and then uses a repeated START. While the programming cycle is running, a busy input stops the block from acknowledging its own address. A master therefore polls for completion by addressing the device until it gets an acknowledge.

The controller states are IDLE (waiting for START), DEV (shifting in the device byte), WHI and WLO (shifting in the high and low address bytes), WDAT (shifting in write data), ACK (driving the acknowledge bit), RDAT (shifting out a read byte), MACK (sampling the master's acknowledge) and IGNORE (address mismatch, busy refusal or master NACK, left only by START or STOP). The transitions are as follows:
- START moves any state to DEV.
- STOP moves any state to IDLE.
- A byte completed in DEV, WHI, WLO or WDAT moves to ACK, or from DEV to IGNORE on a refusal.
- ACK moves to its stored successor (WHI, WLO, WDAT or RDAT) on the falling edge that ends the ninth clock.
- RDAT moves to MACK after eight bits.
- MACK moves back to RDAT on an acknowledge and to IGNORE on a NACK.

Top module: `serial_mem_slave_fe`

## Requirements
- R1: A high-to-low change of SDA while SCL is high is a START. It moves the block to the device-address phase from any state and abandons any half-done header. In particular, a single address byte followed by a repeated START leaves the address counter unchanged. A low-to-high change of SDA while SCL is high is a STOP, which returns the block to idle.
- R2: The device byte is taken MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `dev_sel[2:0]`. Bit 0 is 1 for read and 0 for write. On a mismatch the byte is not acknowledged, and the block leaves SDA released until the next START, acknowledging none of the following bytes.
- R3: Each accepted byte is acknowledged by driving `sda_drive_n` low. The drive starts after the SCL falling edge that ends the eighth bit and stops after the falling edge that ends the ninth clock.
- R4: While `prog_busy` is 1, the device byte is not acknowledged even when it matches. Once `prog_busy` returns to 0 it is acknowledged again.
- R5: A write header carries two address bytes after the device byte. The low five bits of the first byte and all of the second form the 13-bit address; the top three bits of the first byte are ignored. Each data byte then produces one `wr_valid` pulse with `wr_addr` and `wr_data`.
- R6: Between write data bytes only address bits 4..0 advance, wrapping from 31 to 0, while bits 12..5 hold.
- R7: A STOP that ends a write in which at least one data byte was taken gives one `wr_commit` pulse. A STOP after a header with no data byte, or after a read, gives none.
- R8: After a read device byte is acknowledged, the block returns the byte at the counter and then advances the counter by one. Bits go out MSB first, and `sda_drive_n` changes only after an SCL falling edge.
- R9: While the master acknowledges, the block keeps sending bytes from successive addresses, wrapping from 8191 to 0. After a NACK it releases SDA.
- R10: After reset the block is idle, `sda_drive_n` is 1, and `wr_valid`, `wr_commit` and `rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired bus value) |
| dev_sel | input | 3 | Strap levels matched against device byte bits 3..1 |
| prog_busy | input | 1 | Self-timed programming in progress |
| sda_drive_n | output | 1 | Active-low open-drain enable for SDA |
| wr_valid | output | 1 | One-cycle pulse: write byte for the page latch |
| wr_addr | output | 13 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse: STOP ended a write carrying data |
| rd_req | output | 1 | One-cycle read request to the array |
| rd_addr | output | 13 | Address of the read request |
| rd_data | input | 8 | Array byte, valid the clock after `rd_req` and held |

## Verification
The assertions take for granted that each SCL level lasts several system clocks, longer than the synchroniser delay plus one cycle. They also assume that SDA moves only while SCL is low, except at START and STOP, and that `rd_data` settles on the clock after `rd_req` and holds until the next request. The stimulus meets these conditions by holding every bus half period for eight system clocks. It changes the data line only after lowering SCL and opens each bit cell with a full half period. Its array model answers every request on the following clock.

// File: rtl/serial_mem_fe_pkg.sv
package serial_mem_fe_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_WHI,
        S_WLO,
        S_WDAT,
        S_ACK,
        S_RDAT,
        S_MACK,
        S_IGNORE
    } fe_state_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/fe_line_sync.sv
module fe_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q,
    output logic q_prev
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe   <= {STAGES{RST_VAL}};
            q_prev <= RST_VAL;
        end else begin
            pipe   <= {pipe[STAGES-2:0], d_in};
            q_prev <= pipe[STAGES-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/fe_addr_ctr.sv
module fe_addr_ctr #(
    parameter int AW = 13,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_seq,
    input  logic          inc_page,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc_seq) begin
            addr <= addr + 1'b1;
        end else if (inc_page) begin
            addr <= {addr[AW-1:PW], PW'(addr[PW-1:0] + 1'b1)};
        end
    end

    // R6
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !load && !inc_seq) |=> addr[AW-1:PW] == $past(addr[AW-1:PW]));

    // R9
    seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_seq && !load && addr == '1) |=> addr == '0);
endmodule

// File: rtl/serial_mem_slave_fe.sv
module serial_mem_slave_fe
    import serial_mem_fe_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        dev_sel,
    input  logic              prog_busy,
    output logic              sda_drive_n,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    localparam int HI_W = ADDR_W - 8;

    // index 0 = data line, index 1 = clock line
    logic [1:0] raw_in, line_q, line_p;
    assign raw_in = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        fe_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (raw_in[g]),
            .q     (line_q[g]),
            .q_prev(line_p[g])
        );
    end

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    assign sda_s     = line_q[0];
    assign scl_rise  = line_q[1] & ~line_p[1];
    assign scl_fall  = ~line_q[1] & line_p[1];
    assign start_det = line_q[1] & line_p[1] & line_p[0] & ~line_q[0];
    assign stop_det  = line_q[1] & line_p[1] & ~line_p[0] & line_q[0];

    fe_state_t         state, after_ack;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [HI_W-1:0]   addr_hi;
    logic              wr_seen, master_ack;
    logic              ctr_load, ctr_inc_seq, ctr_inc_page;
    logic [ADDR_W-1:0] ctr_addr;

    fe_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctr_load),
        .load_val({addr_hi, shreg}),
        .inc_seq (ctr_inc_seq),
        .inc_page(ctr_inc_page),
        .addr    (ctr_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            after_ack    <= S_IDLE;
            bit_cnt      <= '0;
            shreg        <= '0;
            addr_hi      <= '0;
            wr_seen      <= 1'b0;
            master_ack   <= 1'b0;
            wr_valid     <= 1'b0;
            wr_addr      <= '0;
            wr_data      <= '0;
            wr_commit    <= 1'b0;
            rd_req       <= 1'b0;
            rd_addr      <= '0;
            ctr_load     <= 1'b0;
            ctr_inc_seq  <= 1'b0;
            ctr_inc_page <= 1'b0;
        end else begin
            wr_valid     <= 1'b0;
            wr_commit    <= 1'b0;
            rd_req       <= 1'b0;
            ctr_load     <= 1'b0;
            ctr_inc_seq  <= 1'b0;
            ctr_inc_page <= 1'b0;
            if (start_det) begin
                state   <= S_DEV;
                bit_cnt <= '0;
                wr_seen <= 1'b0;
            end else if (stop_det) begin
                state     <= S_IDLE;
                wr_commit <= wr_seen;
                wr_seen   <= 1'b0;
            end else begin
                unique case (state)
                    S_IDLE, S_IGNORE: begin
                    end
                    S_DEV, S_WHI, S_WLO, S_WDAT: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == S_DEV) begin
                                if (shreg[7:4] == DEV_PREFIX && shreg[3:1] == dev_sel && !prog_busy) begin
                                    state <= S_ACK;
                                    if (shreg[0]) begin
                                        after_ack   <= S_RDAT;
                                        rd_req      <= 1'b1;
                                        rd_addr     <= ctr_addr;
                                        ctr_inc_seq <= 1'b1;
                                    end else begin
                                        after_ack <= S_WHI;
                                    end
                                end else begin
                                    state <= S_IGNORE;
                                end
                            end else if (state == S_WHI) begin
                                addr_hi   <= shreg[HI_W-1:0];
                                state     <= S_ACK;
                                after_ack <= S_WLO;
                            end else if (state == S_WLO) begin
                                ctr_load  <= 1'b1;
                                state     <= S_ACK;
                                after_ack <= S_WDAT;
                            end else begin
                                wr_valid     <= 1'b1;
                                wr_addr      <= ctr_addr;
                                wr_data      <= shreg;
                                ctr_inc_page <= 1'b1;
                                wr_seen      <= 1'b1;
                                state        <= S_ACK;
                                after_ack    <= S_WDAT;
                            end
                        end
                    end
                    S_ACK: begin
                        if (scl_fall) begin
                            state   <= after_ack;
                            bit_cnt <= '0;
                            if (after_ack == S_RDAT) shreg <= rd_data;
                        end
                    end
                    S_RDAT: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                state <= S_MACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    S_MACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_s;
                            if (!sda_s) begin
                                rd_req      <= 1'b1;
                                rd_addr     <= ctr_addr;
                                ctr_inc_seq <= 1'b1;
                            end
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                state   <= S_RDAT;
                                shreg   <= rd_data;
                                bit_cnt <= '0;
                            end else begin
                                state <= S_IGNORE;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            S_ACK:   sda_drive_n = 1'b0;
            S_RDAT:  sda_drive_n = shreg[7];
            default: sda_drive_n = 1'b1;
        endcase
    end

    // R1
    start_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == S_DEV);

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> sda_drive_n);

    // R3
    ack_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACK && $past(state) != S_ACK) |-> $past(scl_fall));

    // R4
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEV && scl_fall && bit_cnt == 4'd8 && prog_busy) |=> state == S_IGNORE);

    // R7
    commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_det));

    // R8
    rdat_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDAT && $past(state) == S_RDAT && sda_drive_n != $past(sda_drive_n))
        |-> $past(scl_fall));
endmodule

// File: tb/test_serial_mem_slave_fe.sv
module test_serial_mem_slave_fe;
    localparam int CLK_PERIOD = 10;
    localparam int HP = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic prog_busy = 1'b0;
    logic sda_bus;
    logic sda_drive_n, wr_valid, wr_commit, rd_req;
    logic [12:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    int n_chk = 0, n_bad = 0, commit_cnt = 0, ref_ptr = 0;
    int exp_q[$];
    logic [7:0] ref_mem [int];
    logic [7:0] arr [int];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & sda_drive_n;

    serial_mem_slave_fe i_serial_mem_slave_fe (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .dev_sel(STRAP), .prog_busy(prog_busy), .sda_drive_n(sda_drive_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [7:0] dflt(int a);
        return 8'((a * 37 + 11) ^ (a >> 5));
    endfunction

    function automatic logic [7:0] ref_rd(int a);
        return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // array model: answers one clock after the request
    always @(posedge clk) begin
        if (rd_req) rd_data <= arr.exists(int'(rd_addr)) ? arr[int'(rd_addr)] : dflt(int'(rd_addr));
    end

    // per-clock reference comparison of the write port
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected write", {19'd0, wr_addr}, -1);
                end else begin
                    check("R5 R6 write addr/data", {11'd0, wr_addr, wr_data}, exp_q.pop_front());
                end
                arr[int'(wr_addr)] = wr_data;
            end
            if (wr_commit) commit_cnt++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(HP);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HP);
            scl_m = 1'b1; tick(HP);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP/2);
        ack = sda_bus; tick(HP/2);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HP);
            scl_m = 1'b1; tick(HP/2);
            b[i] = sda_bus; tick(HP/2);
            scl_m = 1'b0;
        end
        sda_m = mack ? 1'b0 : 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        scl_m = 1'b0;
    endtask

    task automatic do_write(int addr, int n, logic [7:0] seed);
        logic ack;
        int a;
        logic [7:0] d;
        bus_start;
        send_byte(DEV_W, ack); check("R3 device ack", ack, 0);
        send_byte({3'b111, 5'(addr >> 8)}, ack); check("R5 high address ack", ack, 0);
        send_byte(8'(addr), ack); check("R5 low address ack", ack, 0);
        for (int k = 0; k < n; k++) begin
            a = (addr & 'h1FE0) | ((addr + k) & 'h1F);
            d = 8'(seed + k * 17);
            exp_q.push_back((a << 8) | int'(d));
            ref_mem[a] = d;
            send_byte(d, ack); check("R3 data ack", ack, 0);
        end
        bus_stop; tick(6);
        ref_ptr = (addr & 'h1FE0) | ((addr + n) & 'h1F);
    endtask

    // addr < 0 means current-address read
    task automatic do_read(int addr, int n);
        logic ack;
        logic [7:0] b;
        if (addr >= 0) begin
            bus_start;
            send_byte(DEV_W, ack);
            send_byte(8'(addr >> 8), ack);
            send_byte(8'(addr), ack);
            ref_ptr = addr;
        end
        bus_start;
        send_byte(DEV_R, ack); check("R8 read device ack", ack, 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            check(n > 1 ? "R9 sequential byte" : "R8 read byte", b, ref_rd(ref_ptr));
            ref_ptr = (ref_ptr + 1) & 'h1FFF;
        end
        tick(4);
        check("R9 released after NACK", sda_drive_n, 1);
        bus_stop; tick(6);
    endtask

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_up;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        tick(5);
        // R10 reset state
        check("R10 sda released", sda_drive_n, 1);
        check("R10 no write", wr_valid, 0);
        check("R10 no commit", wr_commit, 0);
        check("R10 no read", rd_req, 0);
        rst_n = 1'b1; tick(4);

        // byte write, top bits of high address byte ignored
        do_write('h0310, 1, 8'hA5);
        check("R7 commit after write", commit_cnt, 1);

        // page write wrapping inside the page
        do_write('h0F1E, 4, 8'h3C);
        check("R7 commit after page", commit_cnt, 2);

        // current-address read
        do_read(-1, 1);

        // random read with repeated START
        do_read('h0310, 1);
        check("R7 no commit after read", commit_cnt, 2);

        // sequential read across the top of the space
        do_read('h1FFE, 4);

        // strap mismatch: no ack, following byte ignored
        bus_start;
        send_byte({4'b1010, 3'b011, 1'b0}, ack); check("R2 strap mismatch nack", ack, 1);
        send_byte(8'h00, ack); check("R2 ignored byte nack", ack, 1);
        bus_stop; tick(6);

        // wrong prefix
        bus_start;
        send_byte({4'b1011, STRAP, 1'b0}, ack); check("R2 prefix mismatch nack", ack, 1);
        bus_stop; tick(6);

        // busy refusal, then normal ack
        prog_busy = 1'b1;
        bus_start;
        send_byte(DEV_W, ack); check("R4 busy nack", ack, 1);
        bus_stop; tick(6);
        prog_busy = 1'b0;
        do_read(-1, 1);

        // START mid-header abandons it
        bus_start;
        send_byte(DEV_W, ack);
        send_byte(8'h05, ack); check("R1 high byte ack", ack, 0);
        bus_start;
        send_byte(DEV_R, ack); check("R1 restart ack", ack, 0);
        recv_byte(1'b0, b);
        check("R1 counter kept", b, ref_rd(ref_ptr));
        ref_ptr = (ref_ptr + 1) & 'h1FFF;
        bus_stop; tick(6);

        check("R7 final commit count", commit_cnt, 2);
        check("R5 all writes seen", exp_q.size(), 0);
        finish_up;
    end
endmodule